// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes that frame every access on a multiplexed external memory bus: an active-high address-latch pulse and an active-low program read strobe. It counts out a machine cycle of twelve oscillator clocks, split into six states of two clocks each. Within that cycle it places a latch pulse in the first and fourth states, and a read strobe across each pair of states that follows a latch pulse.

Four inputs describe the machine cycle that is about to begin. The first says that code is being fetched from external memory. The second marks a cycle that moves data to or from external data memory. The third marks a table-read instruction. The fourth is a software control bit that silences the latch strobe. The block samples all four once, at the edge that opens a cycle, and holds them for the whole cycle.

During an external data cycle, the first latch pulse and both read strobes are dropped, so the bus stays free for the data transfer. The silencing bit takes effect only while code runs from internal memory. Even then, it lets the strobe through during data and table-read cycles.

Top module: `bus_strobe_gen`

## Requirements
- R1: With latching allowed and no data cycle, `addr_latch` is high during phases 0-1 and 6-7 of each 12-clock cycle, and low during the other phases. Phase 0 is the first clock after reset release, and phases count modulo 12. This gives one two-clock pulse every six clocks.
- R2: In a cycle with `ext_exec`=1 and `data_xfer`=0, `prog_rd_n` is low during phases 2-5 and 8-11, and high during phases 0-1 and 6-7.
- R3: In a cycle with `data_xfer`=1, the phase 0-1 latch pulse is omitted. The phase 6-7 pulse is still emitted, subject to R5.
- R4: In a cycle with `data_xfer`=1, `prog_rd_n` stays high for all 12 phases.
- R5: In a cycle with `latch_quiet`=1 and `ext_exec`=0, `addr_latch` stays low for the whole cycle unless `data_xfer` or `table_rd` is 1. When either of those is 1, the pulses follow R1 and R3.
- R6: In a cycle with `ext_exec`=0, `prog_rd_n` stays high for all 12 phases.
- R7: While `rst_n` is low, `addr_latch` is 0 and `prog_rd_n` is 1. The first rising edge after release opens a new cycle at phase 0.
- R8: In a cycle with `ext_exec`=1, `latch_quiet` has no effect on `addr_latch`.
- R9: The four class inputs are sampled only at the edge that enters phase 0. A change at any other time has no effect until the next cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_exec | input | 1 | Code for the coming cycle is fetched from external memory |
| data_xfer | input | 1 | The coming cycle is an external data-memory access |
| table_rd | input | 1 | The coming cycle belongs to a table-read instruction |
| latch_quiet | input | 1 | Silence the latch strobe outside data and table-read cycles |
| addr_latch | output | 1 | Address-latch pulse, active high |
| prog_rd_n | output | 1 | Program read strobe, active low |

## Verification
Three rules can act in the same cycle. The data-cycle suppression and the quiet rule together decide the fourth-state pulse. The external-execution override and the quiet rule together decide whether latching is allowed. The bench provokes these overlaps by raising `latch_quiet` together with `data_xfer`, with `table_rd`, and with `ext_exec`, both in directed cycles and in a long random run. It also toggles the class inputs in the middle of a cycle. A behavioural model, built from phase arithmetic on integers, predicts both strobes for every clock. The bench compares the two strobes against this model at each falling edge, so any overlap the design resolves differently shows up as a miscompare on the exact phase.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef struct packed {
    logic ext_exec;
    logic data_xfer;
    logic table_rd;
    logic latch_quiet;
  } cyc_class_t;

  localparam cyc_class_t CLASS_IDLE = '0;

  // latching is allowed unless quiet is set while running internal code
  // outside a data or table-read cycle
  function automatic logic latch_allowed(cyc_class_t c);
    return !c.latch_quiet || c.ext_exec || c.data_xfer || c.table_rd;
  endfunction

  // state index st within a cycle of 'states' states
  function automatic logic latch_slot(int unsigned st, int unsigned states,
                                      logic data);
    return ((st == 0) && !data) || (st == states / 2);
  endfunction

  function automatic logic read_slot(int unsigned st, int unsigned states);
    return (st != 0) && (st != states / 2);
  endfunction

endpackage

// File: rtl/bsg_phase_ctr.sv
module bsg_phase_ctr #(
  parameter int unsigned PHASES = 12,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_d,
  output logic          cycle_start
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  assign cycle_start = (phase_q == LAST);

  always_comb begin
    if (cycle_start) phase_d = '0;
    else             phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= LAST;
    else        phase_q <= phase_d;
  end

  // R7: a cycle is only ever entered from its last phase
  p_phase_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) |-> ($past(phase_q) == LAST));

endmodule

// File: rtl/bsg_class_reg.sv
module bsg_class_reg
  import bsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_start,
  input  cyc_class_t cls_in,
  output cyc_class_t cls_q,
  output cyc_class_t cls_d
);
  assign cls_d = cycle_start ? cls_in : cls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cls_q <= CLASS_IDLE;
    else        cls_q <= cls_d;
  end

  // R9: the class holds through the cycle
  p_class_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(cls_q));

endmodule

// File: rtl/bsg_strobe_out.sv
module bsg_strobe_out
  import bsg_pkg::*;
#(
  parameter int unsigned CLKS_PER_STATE = 2,
  parameter int unsigned STATES = 6,
  localparam int unsigned PHASES = CLKS_PER_STATE * STATES,
  localparam int unsigned PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_d,
  input  cyc_class_t    cls_d,
  output logic          addr_latch,
  output logic          prog_rd_n
);
  int unsigned st_n;
  logic        latch_n;
  logic        rd_n;

  always_comb begin
    st_n    = 32'(phase_d) / CLKS_PER_STATE;
    latch_n = latch_allowed(cls_d) && latch_slot(st_n, STATES, cls_d.data_xfer);
    rd_n    = !(cls_d.ext_exec && !cls_d.data_xfer && read_slot(st_n, STATES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_latch <= 1'b0;
      prog_rd_n  <= 1'b1;
    end else begin
      addr_latch <= latch_n;
      prog_rd_n  <= rd_n;
    end
  end

  // R1/R2: latch pulse and read strobe never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_latch && !prog_rd_n));

  generate
    if (CLKS_PER_STATE > 1) begin : g_wide
      // R1: a latch pulse lasts more than one clock
      p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_latch) |=> addr_latch);
    end
  endgenerate

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int unsigned CLKS_PER_STATE = 2,
  parameter int unsigned STATES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_exec,
  input  logic data_xfer,
  input  logic table_rd,
  input  logic latch_quiet,
  output logic addr_latch,
  output logic prog_rd_n
);
  localparam int unsigned PHASES = CLKS_PER_STATE * STATES;
  localparam int unsigned PW = $clog2(PHASES);
  localparam int unsigned MID = (STATES / 2) * CLKS_PER_STATE;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;
  logic          cycle_start;
  cyc_class_t    cls_in;
  cyc_class_t    cls_q;
  cyc_class_t    cls_d;

  assign cls_in = '{ext_exec: ext_exec, data_xfer: data_xfer,
                    table_rd: table_rd, latch_quiet: latch_quiet};

  bsg_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d),
    .cycle_start(cycle_start)
  );

  bsg_class_reg u_class (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .cls_in(cls_in),
    .cls_q(cls_q), .cls_d(cls_d)
  );

  bsg_strobe_out #(.CLKS_PER_STATE(CLKS_PER_STATE), .STATES(STATES)) u_out (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .cls_d(cls_d),
    .addr_latch(addr_latch), .prog_rd_n(prog_rd_n)
  );

  // R6: no read strobe for internal code
  p_rd_internal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_q.ext_exec |-> prog_rd_n);

  // R4: no read strobe in a data cycle
  p_rd_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cls_q.data_xfer |-> prog_rd_n);

  // R5: quiet silences latching outside data and table cycles
  p_quiet_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q.latch_quiet && !cls_q.ext_exec && !cls_q.data_xfer && !cls_q.table_rd)
      |-> !addr_latch);

  // R3: first latch slot skipped in a data cycle
  p_data_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q.data_xfer && (32'(phase_q) < CLKS_PER_STATE)) |-> !addr_latch);

  // R8: external execution always gets the mid-cycle latch pulse
  p_ext_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q.ext_exec && (32'(phase_q) == MID)) |-> addr_latch);

  // R2: external fetch cycle strobes right after the first state
  p_rd_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q.ext_exec && !cls_q.data_xfer && (32'(phase_q) == CLKS_PER_STATE))
      |-> !prog_rd_n);

endmodule

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_exec = 1'b0, data_xfer = 1'b0, table_rd = 1'b0, latch_quiet = 1'b0;
  logic addr_latch, prog_rd_n;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  string focus = "R7";

  // model state
  int k = 11;
  bit m_ext = 0, m_dat = 0, m_tab = 0, m_qui = 0;
  bit in_reset = 1;

  always #5 clk = ~clk;

  bus_strobe_gen u_bus_strobe_gen (
    .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .data_xfer(data_xfer),
    .table_rd(table_rd), .latch_quiet(latch_quiet),
    .addr_latch(addr_latch), .prog_rd_n(prog_rd_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      in_reset = 1; k = 11;
      m_ext = 0; m_dat = 0; m_tab = 0; m_qui = 0;
    end else begin
      in_reset = 0;
      k = (k + 1) % 12;
      if (k == 0) begin
        m_ext = ext_exec; m_dat = data_xfer; m_tab = table_rd; m_qui = latch_quiet;
      end
    end
  end

  always @(negedge clk) begin
    bit exp_al, exp_rd, allow;
    int st;
    string tal, trd;
    if (in_reset) begin
      exp_al = 0; exp_rd = 1; tal = "R7"; trd = "R7";
    end else begin
      st = k / 2;
      allow = !m_qui || m_ext || m_dat || m_tab;
      exp_al = allow && ((st == 0 && !m_dat) || st == 3);
      exp_rd = !(m_ext && !m_dat && st != 0 && st != 3);
      tal = m_qui ? (m_ext ? "R8" : "R5") : (m_dat ? "R3" : "R1");
      trd = m_dat ? "R4" : (m_ext ? "R2" : "R6");
    end
    vectors++;
    if (addr_latch !== exp_al) begin
      errors++;
      $display("FAIL %s (%s) addr_latch phase %0d: got %b expected %b", tal, focus, k, addr_latch, exp_al);
    end
    if (prog_rd_n !== exp_rd) begin
      errors++;
      $display("FAIL %s (%s) prog_rd_n phase %0d: got %b expected %b", trd, focus, k, prog_rd_n, exp_rd);
    end
  end

  task automatic set_class(bit e, bit d, bit t, bit q);
    ext_exec = e; data_xfer = d; table_rd = t; latch_quiet = q;
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R7: reset state held for several clocks
    focus = "R7";
    clocks(4);
    rst_n = 1'b1;
    focus = "R1"; set_class(0, 0, 0, 0); clocks(36);
    focus = "R2"; set_class(1, 0, 0, 0); clocks(36);
    focus = "R3 R4"; set_class(1, 1, 0, 0); clocks(12);
    set_class(1, 0, 0, 0); clocks(12);
    focus = "R3"; set_class(0, 1, 0, 0); clocks(24);
    focus = "R5"; set_class(0, 0, 0, 1); clocks(24);
    focus = "R5 table"; set_class(0, 0, 1, 1); clocks(24);
    focus = "R5 data"; set_class(0, 1, 0, 1); clocks(24);
    focus = "R8"; set_class(1, 0, 0, 1); clocks(24);
    focus = "R8 data"; set_class(1, 1, 0, 1); clocks(24);
    // R9: mid-cycle toggles must be ignored
    focus = "R9";
    for (int c = 0; c < 8; c++) begin
      set_class(c[0], c[1], c[2], ~c[0]); clocks(3);
      set_class(~c[0], ~c[1], c[2], c[0]); clocks(5);
      set_class(c[1], c[0], ~c[2], c[1]); clocks(4);
    end
    // R7: reset in mid-cycle, then restart at phase 0
    focus = "R7 restart";
    set_class(1, 0, 0, 0); clocks(5);
    rst_n = 1'b0; clocks(3); rst_n = 1'b1; clocks(24);
    focus = "random";
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom;
      set_class(r[0], r[1] & r[2], r[3], r[4]);
      clocks(1 + (r[8:5] % 13));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule